// File: doc/BRIEF.md
# Double-precision floating-point instruction decoder

This block turns one 32-bit instruction word into a decoded double-precision operation for a floating-point pipeline. It recognises the four fused multiply-add flavours, the basic add, subtract, multiply, divide and square-root operations, the integer and single-precision conversions, sign injection, minimum and maximum, the three compares, classify, and the two raw bit moves between register files. For each word it reports an operation code, the four register index fields, the resolved 3-bit rounding mode, an illegal flag, and markers telling the datapath which fused operands to negate and whether the result or source lives in the integer register file.

Legality depends on configuration inputs that arrive with each word. These are the integer register width (32 or 64 bits), whether a separate floating-point register file exists, and whether doubles are instead held in integer register pairs. A fourth input is the dynamic rounding mode taken from the control register. Words come in on a valid/ready stream, and decoded results leave on a second valid/ready stream through a single output register. A result appears one clock after the word is accepted and holds still while the consumer stalls. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure passes straight through with no extra buffering.

Top module: `dp_instr_decoder`

## Requirements
- R1: Major opcodes 0x43, 0x47, 0x4B and 0x4F decode to the fused operations only when bits 26..25 equal 01. Any other value in that field is illegal. The third source index comes from bits 31..27.
- R2: The 0x47 form raises out_neg_add. The 0x4B form raises out_neg_prod. The 0x4F form raises both. The 0x43 form raises neither.
- R3: With opcode 0x53, funct7 (bits 31..25) 0000001/0000101/0001001/0001101 give add/sub/mul/div. Funct7 0101101 gives square root only when bits 24..20 are zero, and is illegal otherwise.
- R4: Funct7 1100001 is double-to-integer and 1101001 is integer-to-double. Bits 24..20 select signed 32 (0), unsigned 32 (1), signed 64 (2) or unsigned 64 (3); any other value is illegal. The 64-bit variants are illegal when cfg_wide_int is 0. Funct7 0100000 with field 1 narrows to single, and funct7 0100001 with field 0 widens from single.
- R5: Funct7 0010001 with funct3 (bits 14..12) 0/1/2 gives sign copy/negate/xor. Funct7 0010101 with funct3 0/1 gives min/max. Funct7 1010001 with funct3 2/1/0 gives equal/less-than/less-or-equal. Funct7 1110001 with funct3 1 and a zero field at 24..20 gives classify. Any other funct3 for these is illegal.
- R6: Move-to-integer (funct7 1110001, funct3 0) and move-from-integer (funct7 1111001, funct3 0), each with field 24..20 zero, are legal only when cfg_fp_regfile and cfg_wide_int are both 1.
- R7: For operations that carry a rounding field (bits 14..12), values 101 and 110 are illegal. Value 111 takes dyn_rm, and the word is illegal if dyn_rm is 101 or above. out_rm reports the resolved mode. Operations without a rounding field report 000 and ignore dyn_rm.
- R8: When cfg_fp_in_int is 1 and cfg_wide_int is 0, every double-width operand index must be even. Integer-side operands are exempt: the destination of double-to-integer and compares, and the source of integer-to-double.
- R9: When cfg_fp_regfile and cfg_fp_in_int are both 0, every word is illegal.
- R10: out_int_dst is 1 for double-to-integer, compares, classify and move-to-integer. out_int_src is 1 for integer-to-double and move-from-integer. Both are 0 for every other operation.
- R11: Any encoding not listed above, any other major opcode among them, gives out_illegal=1 with out_op=0, out_rm=000 and all four marker outputs 0.
- R12: A word accepted on a rising edge (in_valid and in_ready) appears with out_valid=1 right after that edge. in_ready equals !out_valid || out_ready. While out_valid is 1 and out_ready is 0, all outputs hold.
- R13: out_op codes are: 0 none; 1-4 fused add, sub, negated sub, negated add; 5-8 add, sub, mul, div; 9 sqrt; 10-13 to int s32, u32, s64, u64; 14-17 from int s32, u32, s64, u64; 18 narrow; 19 widen; 20-22 sign copy, negate, xor; 23 min; 24 max; 25-27 eq, lt, le; 28 classify; 29 move to int; 30 move from int. Index fields pass through unchanged: rd bits 11..7, rs1 19..15, rs2 24..20, rs3 31..27.
- R14: While rst_n is 0, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_instr | input | 32 | Instruction word |
| cfg_wide_int | input | 1 | 1 when the integer registers are 64 bits wide |
| cfg_fp_regfile | input | 1 | 1 when a separate floating-point register file exists |
| cfg_fp_in_int | input | 1 | 1 when doubles are held in integer registers |
| dyn_rm | input | 3 | Dynamic rounding mode from the control register |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_op | output | 5 | Operation code (R13) |
| out_rd | output | 5 | Destination index |
| out_rs1 | output | 5 | First source index |
| out_rs2 | output | 5 | Second source index |
| out_rs3 | output | 5 | Third source index |
| out_rm | output | 3 | Resolved rounding mode |
| out_illegal | output | 1 | Word is not a legal operation in this configuration |
| out_neg_prod | output | 1 | Negate the product term of the fused operation |
| out_neg_add | output | 1 | Negate the addend of the fused operation |
| out_int_dst | output | 1 | Result goes to the integer register file |
| out_int_src | output | 1 | Source comes from the integer register file |

## Verification
The decoder holds state only in its output register. A wrong state there shows as an output that changes while the consumer stalls, as a result arriving a cycle late or being dropped or duplicated, or as fields that mismatch the word that was accepted. The scoreboard catches all of these on the very next transfer, because every accepted word is paired in order with exactly one expected result. A legality slip, such as a missed even-pair rule, a wrong width gate or an unresolved dynamic rounding mode, shows on the first transfer of the affected word as a wrong out_illegal or out_rm. The tests run under a back-pressure pattern so that held outputs are compared too.

// File: rtl/dpdec_pkg.sv
package dpdec_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int RM_W    = 3;
  localparam int OP_W    = 5;
  localparam int NUM_OPND = 4;   // operand order in masks: 0 rd, 1 rs1, 2 rs2, 3 rs3

  typedef enum logic [OP_W-1:0] {
    OP_NONE, OP_MADD, OP_MSUB, OP_NMSUB, OP_NMADD,
    OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SQRT,
    OP_F2I_S32, OP_F2I_U32, OP_F2I_S64, OP_F2I_U64,
    OP_I2F_S32, OP_I2F_U32, OP_I2F_S64, OP_I2F_U64,
    OP_NARROW, OP_WIDEN,
    OP_SIGN_COPY, OP_SIGN_NEG, OP_SIGN_XOR, OP_MIN, OP_MAX,
    OP_CMP_EQ, OP_CMP_LT, OP_CMP_LE, OP_CLASSIFY,
    OP_MOVE_TO_INT, OP_MOVE_FROM_INT
  } dp_op_e;

  typedef struct packed {
    dp_op_e              op;
    logic [NUM_OPND-1:0] pair_mask;  // double-width operands subject to even rule
    logic                uses_rm;
    logic                need_wide;
    logic                need_fpreg;
    logic                neg_prod;
    logic                neg_add;
    logic                int_dst;
    logic                int_src;
  } dec_info_t;
endpackage

// File: rtl/dpdec_opsel.sv
module dpdec_opsel
  import dpdec_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [6:0] funct7,
  input  logic [4:0] sel_field,  // bits 24..20
  input  logic [2:0] funct3,
  output dec_info_t  info
);
  logic [1:0] fmt;
  assign fmt = funct7[1:0];

  always_comb begin
    info    = '0;
    info.op = OP_NONE;
    case (opcode)
      7'h43, 7'h47, 7'h4B, 7'h4F: begin
        if (fmt == 2'b01) begin
          info.pair_mask = 4'b1111;
          info.uses_rm   = 1'b1;
          case (opcode[3:2])
            2'd0: info.op = OP_MADD;
            2'd1: begin info.op = OP_MSUB;  info.neg_add = 1'b1; end
            2'd2: begin info.op = OP_NMSUB; info.neg_prod = 1'b1; end
            default: begin
              info.op = OP_NMADD; info.neg_prod = 1'b1; info.neg_add = 1'b1;
            end
          endcase
        end
      end
      7'h53: begin
        case (funct7)
          7'b0000001, 7'b0000101, 7'b0001001, 7'b0001101: begin
            info.pair_mask = 4'b0111;
            info.uses_rm   = 1'b1;
            case (funct7[3:2])
              2'd0: info.op = OP_ADD;
              2'd1: info.op = OP_SUB;
              2'd2: info.op = OP_MUL;
              default: info.op = OP_DIV;
            endcase
          end
          7'b0101101: if (sel_field == 5'd0) begin
            info.op = OP_SQRT; info.pair_mask = 4'b0011; info.uses_rm = 1'b1;
          end
          7'b1100001: begin
            info.uses_rm = 1'b1;
            info.int_dst = 1'b1;
            case (sel_field)
              5'd0: begin info.op = OP_F2I_S32; info.pair_mask = 4'b0010; end
              5'd1: begin info.op = OP_F2I_U32; info.pair_mask = 4'b0010; end
              5'd2: begin info.op = OP_F2I_S64; info.need_wide = 1'b1; end
              5'd3: begin info.op = OP_F2I_U64; info.need_wide = 1'b1; end
              default: info = '0;
            endcase
          end
          7'b1101001: begin
            info.uses_rm = 1'b1;
            info.int_src = 1'b1;
            case (sel_field)
              5'd0: begin info.op = OP_I2F_S32; info.pair_mask = 4'b0001; end
              5'd1: begin info.op = OP_I2F_U32; info.pair_mask = 4'b0001; end
              5'd2: begin info.op = OP_I2F_S64; info.need_wide = 1'b1; end
              5'd3: begin info.op = OP_I2F_U64; info.need_wide = 1'b1; end
              default: info = '0;
            endcase
          end
          7'b0100000: if (sel_field == 5'd1) begin
            info.op = OP_NARROW; info.pair_mask = 4'b0010; info.uses_rm = 1'b1;
          end
          7'b0100001: if (sel_field == 5'd0) begin
            info.op = OP_WIDEN; info.pair_mask = 4'b0001; info.uses_rm = 1'b1;
          end
          7'b0010001: begin
            info.pair_mask = 4'b0111;
            case (funct3)
              3'd0: info.op = OP_SIGN_COPY;
              3'd1: info.op = OP_SIGN_NEG;
              3'd2: info.op = OP_SIGN_XOR;
              default: info = '0;
            endcase
          end
          7'b0010101: begin
            info.pair_mask = 4'b0111;
            case (funct3)
              3'd0: info.op = OP_MIN;
              3'd1: info.op = OP_MAX;
              default: info = '0;
            endcase
          end
          7'b1010001: begin
            info.pair_mask = 4'b0110;
            info.int_dst   = 1'b1;
            case (funct3)
              3'd2: info.op = OP_CMP_EQ;
              3'd1: info.op = OP_CMP_LT;
              3'd0: info.op = OP_CMP_LE;
              default: info = '0;
            endcase
          end
          7'b1110001: if (sel_field == 5'd0) begin
            info.int_dst = 1'b1;
            case (funct3)
              3'd1: begin info.op = OP_CLASSIFY; info.pair_mask = 4'b0010; end
              3'd0: begin
                info.op = OP_MOVE_TO_INT; info.need_wide = 1'b1; info.need_fpreg = 1'b1;
              end
              default: info = '0;
            endcase
          end
          7'b1111001: if (sel_field == 5'd0 && funct3 == 3'd0) begin
            info.op = OP_MOVE_FROM_INT; info.int_src = 1'b1;
            info.need_wide = 1'b1; info.need_fpreg = 1'b1;
          end
          default: info = '0;
        endcase
      end
      default: info = '0;
    endcase
  end
endmodule

// File: rtl/dpdec_rm_resolve.sv
module dpdec_rm_resolve
  import dpdec_pkg::*;
(
  input  logic [RM_W-1:0] rm_field,
  input  logic [RM_W-1:0] dyn_rm,
  output logic [RM_W-1:0] rm_eff,
  output logic            rm_bad
);
  localparam logic [RM_W-1:0] RM_DYN      = 3'b111;
  localparam logic [RM_W-1:0] RM_FIRST_BAD = 3'b101;

  always_comb begin
    rm_eff = (rm_field == RM_DYN) ? dyn_rm : rm_field;
    // reserved static codes and an out-of-range dynamic mode share one test
    rm_bad = (rm_eff >= RM_FIRST_BAD);
  end
endmodule

// File: rtl/dpdec_pair_check.sv
module dpdec_pair_check
  import dpdec_pkg::*;
(
  input  logic                enforce,
  input  logic [NUM_OPND-1:0] mask,
  input  logic [NUM_OPND-1:0] idx_lsb,
  output logic                pair_bad
);
  logic [NUM_OPND-1:0] odd_hit;
  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    assign odd_hit[i] = mask[i] & idx_lsb[i];
  end
  assign pair_bad = enforce & (|odd_hit);
endmodule

// File: rtl/dp_instr_decoder.sv
module dp_instr_decoder
  import dpdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               cfg_wide_int,
  input  logic               cfg_fp_regfile,
  input  logic               cfg_fp_in_int,
  input  logic [RM_W-1:0]    dyn_rm,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OP_W-1:0]    out_op,
  output logic [REG_W-1:0]   out_rd,
  output logic [REG_W-1:0]   out_rs1,
  output logic [REG_W-1:0]   out_rs2,
  output logic [REG_W-1:0]   out_rs3,
  output logic [RM_W-1:0]    out_rm,
  output logic               out_illegal,
  output logic               out_neg_prod,
  output logic               out_neg_add,
  output logic               out_int_dst,
  output logic               out_int_src
);
  logic [REG_W-1:0] f_rd, f_rs1, f_rs2, f_rs3;
  logic [2:0]       f_funct3;
  logic [6:0]       f_funct7, f_opcode;

  assign f_opcode = in_instr[6:0];
  assign f_rd     = in_instr[11:7];
  assign f_funct3 = in_instr[14:12];
  assign f_rs1    = in_instr[19:15];
  assign f_rs2    = in_instr[24:20];
  assign f_funct7 = in_instr[31:25];
  assign f_rs3    = in_instr[31:27];

  dec_info_t        info;
  logic [RM_W-1:0]  rm_eff;
  logic             rm_bad, pair_bad, fpu_on, legal;

  dpdec_opsel u_opsel (
    .opcode(f_opcode), .funct7(f_funct7), .sel_field(f_rs2),
    .funct3(f_funct3), .info(info)
  );

  dpdec_rm_resolve u_rm (
    .rm_field(f_funct3), .dyn_rm(dyn_rm), .rm_eff(rm_eff), .rm_bad(rm_bad)
  );

  dpdec_pair_check u_pair (
    .enforce (cfg_fp_in_int & ~cfg_wide_int),
    .mask    (info.pair_mask),
    .idx_lsb ({f_rs3[0], f_rs2[0], f_rs1[0], f_rd[0]}),
    .pair_bad(pair_bad)
  );

  assign fpu_on = cfg_fp_regfile | cfg_fp_in_int;
  assign legal  = (info.op != OP_NONE) & fpu_on
                & (~info.need_wide  | cfg_wide_int)
                & (~info.need_fpreg | cfg_fp_regfile)
                & (~info.uses_rm    | ~rm_bad)
                & ~pair_bad;

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_op       <= '0;
      out_rd       <= '0;
      out_rs1      <= '0;
      out_rs2      <= '0;
      out_rs3      <= '0;
      out_rm       <= '0;
      out_illegal  <= 1'b0;
      out_neg_prod <= 1'b0;
      out_neg_add  <= 1'b0;
      out_int_dst  <= 1'b0;
      out_int_src  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_rd       <= f_rd;
        out_rs1      <= f_rs1;
        out_rs2      <= f_rs2;
        out_rs3      <= f_rs3;
        out_illegal  <= ~legal;
        out_op       <= legal ? info.op : OP_NONE;
        out_rm       <= (legal && info.uses_rm) ? rm_eff : '0;
        out_neg_prod <= legal & info.neg_prod;
        out_neg_add  <= legal & info.neg_add;
        out_int_dst  <= legal & info.int_dst;
        out_int_src  <= legal & info.int_src;
      end
    end
  end

  // R12: a stalled result stays put
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_rm)
      && $stable(out_illegal) && $stable(out_rd) && $stable(out_rs1)
      && $stable(out_rs2) && $stable(out_rs3));

  // R12: an accepted word is visible after exactly one edge
  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R11: an illegal result carries no operation and no markers
  assert_illegal_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_op == '0 && out_rm == '0 && !out_neg_prod
      && !out_neg_add && !out_int_dst && !out_int_src);

  // R7: a legal result never carries a reserved rounding mode
  assert_rm_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> out_rm <= 3'd4);

  // R2: negation markers only accompany fused operations
  assert_neg_fused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_neg_prod || out_neg_add) |-> out_op >= 5'd1 && out_op <= 5'd4);

  // R10: a result never both reads and writes the integer file as its move side
  assert_int_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_int_dst && out_int_src));
endmodule

// File: tb/tb_dp_instr_decoder.sv
module tb_dp_instr_decoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_instr;
  logic        cfg_wide_int, cfg_fp_regfile, cfg_fp_in_int;
  logic [2:0]  dyn_rm, out_rm;
  logic [4:0]  out_op, out_rd, out_rs1, out_rs2, out_rs3;
  logic        out_illegal, out_neg_prod, out_neg_add, out_int_dst, out_int_src;

  dp_instr_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .cfg_wide_int(cfg_wide_int), .cfg_fp_regfile(cfg_fp_regfile),
    .cfg_fp_in_int(cfg_fp_in_int), .dyn_rm(dyn_rm), .out_valid(out_valid),
    .out_ready(out_ready), .out_op(out_op), .out_rd(out_rd), .out_rs1(out_rs1),
    .out_rs2(out_rs2), .out_rs3(out_rs3), .out_rm(out_rm), .out_illegal(out_illegal),
    .out_neg_prod(out_neg_prod), .out_neg_add(out_neg_add),
    .out_int_dst(out_int_dst), .out_int_src(out_int_src)
  );

  // marker flags packed as {illegal, neg_prod, neg_add, int_dst, int_src}
  localparam logic [4:0] F_ILL = 5'b10000, F_NP = 5'b01000, F_NA = 5'b00100,
                         F_ID = 5'b00010, F_IS = 5'b00001, F_0 = 5'b00000;
  // configuration packed as {wide_int, fp_regfile, fp_in_int}
  localparam logic [2:0] C64 = 3'b110, C32 = 3'b010, ZX32 = 3'b001,
                         ZX64 = 3'b101, NOFP = 3'b100;

  typedef struct {
    logic [31:0] instr;
    logic [4:0]  op;
    logic [2:0]  rm;
    logic [4:0]  fl;
    string       req;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0, cyc = 0;
  logic stall = 1'b0, bp = 1'b0, done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #2;
    if (stall) out_ready = 1'b0;
    else if (bp) out_ready = (cyc % 3 != 0);
    else out_ready = 1'b1;
  end

  function automatic logic [31:0] fz(input logic [6:0] opc, input logic [1:0] fmt,
      input logic [4:0] rs3, input logic [4:0] rs2, input logic [4:0] rs1,
      input logic [2:0] rm, input logic [4:0] rd);
    return {rs3, fmt, rs2, rs1, rm, rd, opc};
  endfunction

  function automatic logic [31:0] r53(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'h53};
  endfunction

  task automatic chk(input string req, input logic ok, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic send(input string req, input logic [31:0] ins, input logic [2:0] cfg,
      input logic [2:0] dyn, input logic [4:0] eop, input logic [2:0] erm,
      input logic [4:0] efl);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_instr = ins; dyn_rm = dyn;
    {cfg_wide_int, cfg_fp_regfile, cfg_fp_in_int} = cfg;
    e.instr = ins; e.op = eop; e.rm = erm; e.fl = efl; e.req = req;
    q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      logic [4:0] afl;
      logic [19:0] aregs, eregs;
      checks++;
      afl = {out_illegal, out_neg_prod, out_neg_add, out_int_dst, out_int_src};
      aregs = {out_rs3, out_rs2, out_rs1, out_rd};
      if (q.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected result actual op=%0d expected none", out_op);
      end else begin
        e = q.pop_front();
        eregs = {e.instr[31:27], e.instr[24:20], e.instr[19:15], e.instr[11:7]};
        if (out_op !== e.op || out_rm !== e.rm || afl !== e.fl || aregs !== eregs) begin
          failures++;
          $display("FAIL %s instr=%h actual op=%0d rm=%0d fl=%b regs=%h expected op=%0d rm=%0d fl=%b regs=%h",
                   e.req, e.instr, out_op, out_rm, afl, aregs, e.op, e.rm, e.fl, eregs);
        end
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; dyn_rm = '0;
    {cfg_wide_int, cfg_fp_regfile, cfg_fp_in_int} = C64;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R14", out_valid === 1'b0, "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R14", in_ready === 1'b1, "in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // R1 and R12 latency: one edge from accept to visible result
    send("R1", fz(7'h43, 2'b01, 5'd3, 5'd2, 5'd1, 3'd0, 5'd4), C64, 3'd0, 5'd1, 3'd0, F_0);
    chk("R12", out_valid === 1'b1, "valid one cycle after accept", {31'd0, out_valid}, 32'd1);

    bp = 1'b1;
    // R2 negation markers
    send("R2", fz(7'h47, 2'b01, 5'd9, 5'd8, 5'd7, 3'd1, 5'd6), C64, 3'd0, 5'd2, 3'd1, F_NA);
    send("R2", fz(7'h4B, 2'b01, 5'd9, 5'd8, 5'd7, 3'd2, 5'd6), C64, 3'd0, 5'd3, 3'd2, F_NP);
    send("R2", fz(7'h4F, 2'b01, 5'd9, 5'd8, 5'd7, 3'd3, 5'd6), C64, 3'd0, 5'd4, 3'd3, F_NP | F_NA);
    send("R1", fz(7'h43, 2'b00, 5'd3, 5'd2, 5'd1, 3'd0, 5'd4), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R1", fz(7'h4F, 2'b11, 5'd3, 5'd2, 5'd1, 3'd0, 5'd4), C64, 3'd0, 5'd0, 3'd0, F_ILL);

    // R3 arithmetic
    send("R3", r53(7'b0000001, 5'd2, 5'd1, 3'd2, 5'd3), C64, 3'd0, 5'd5, 3'd2, F_0);
    send("R3", r53(7'b0000101, 5'd2, 5'd1, 3'd3, 5'd3), C64, 3'd0, 5'd6, 3'd3, F_0);
    send("R3", r53(7'b0001001, 5'd2, 5'd1, 3'd4, 5'd3), C64, 3'd0, 5'd7, 3'd4, F_0);
    send("R3", r53(7'b0001101, 5'd2, 5'd1, 3'd0, 5'd3), C64, 3'd0, 5'd8, 3'd0, F_0);
    send("R3", r53(7'b0101101, 5'd0, 5'd5, 3'd1, 5'd6), C64, 3'd0, 5'd9, 3'd1, F_0);
    send("R3", r53(7'b0101101, 5'd1, 5'd5, 3'd1, 5'd6), C64, 3'd0, 5'd0, 3'd0, F_ILL);

    // R4 conversions, R10 integer-side markers
    send("R4", r53(7'b1100001, 5'd0, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd10, 3'd0, F_ID);
    send("R4", r53(7'b1100001, 5'd1, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd11, 3'd0, F_ID);
    send("R4", r53(7'b1100001, 5'd2, 5'd1, 3'd1, 5'd2), C64, 3'd0, 5'd12, 3'd1, F_ID);
    send("R10", r53(7'b1100001, 5'd3, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd13, 3'd0, F_ID);
    send("R10", r53(7'b1101001, 5'd0, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd14, 3'd0, F_IS);
    send("R4", r53(7'b1101001, 5'd1, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd15, 3'd0, F_IS);
    send("R4", r53(7'b1101001, 5'd2, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd16, 3'd0, F_IS);
    send("R4", r53(7'b1101001, 5'd3, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd17, 3'd0, F_IS);
    send("R4", r53(7'b1100001, 5'd4, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R4", r53(7'b1100001, 5'd2, 5'd1, 3'd0, 5'd2), C32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R4", r53(7'b1101001, 5'd3, 5'd1, 3'd0, 5'd2), C32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R4", r53(7'b1100001, 5'd0, 5'd1, 3'd0, 5'd2), C32, 3'd0, 5'd10, 3'd0, F_ID);
    send("R4", r53(7'b0100000, 5'd1, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd18, 3'd0, F_0);
    send("R4", r53(7'b0100001, 5'd0, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd19, 3'd0, F_0);
    send("R4", r53(7'b0100000, 5'd0, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd0, 3'd0, F_ILL);

    // R5 sign injection, min/max, compares, classify
    send("R5", r53(7'b0010001, 5'd2, 5'd1, 3'd0, 5'd3), C64, 3'd0, 5'd20, 3'd0, F_0);
    send("R5", r53(7'b0010001, 5'd2, 5'd1, 3'd1, 5'd3), C64, 3'd0, 5'd21, 3'd0, F_0);
    send("R5", r53(7'b0010001, 5'd2, 5'd1, 3'd2, 5'd3), C64, 3'd0, 5'd22, 3'd0, F_0);
    send("R5", r53(7'b0010001, 5'd2, 5'd1, 3'd3, 5'd3), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R5", r53(7'b0010101, 5'd2, 5'd1, 3'd0, 5'd3), C64, 3'd0, 5'd23, 3'd0, F_0);
    send("R5", r53(7'b0010101, 5'd2, 5'd1, 3'd1, 5'd3), C64, 3'd0, 5'd24, 3'd0, F_0);
    send("R5", r53(7'b0010101, 5'd2, 5'd1, 3'd2, 5'd3), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R5", r53(7'b1010001, 5'd2, 5'd1, 3'd2, 5'd3), C64, 3'd0, 5'd25, 3'd0, F_ID);
    send("R5", r53(7'b1010001, 5'd2, 5'd1, 3'd1, 5'd3), C64, 3'd0, 5'd26, 3'd0, F_ID);
    send("R5", r53(7'b1010001, 5'd2, 5'd1, 3'd0, 5'd3), C64, 3'd0, 5'd27, 3'd0, F_ID);
    send("R5", r53(7'b1010001, 5'd2, 5'd1, 3'd3, 5'd3), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R5", r53(7'b1110001, 5'd0, 5'd1, 3'd1, 5'd3), C64, 3'd0, 5'd28, 3'd0, F_ID);
    send("R5", r53(7'b1110001, 5'd1, 5'd1, 3'd1, 5'd3), C64, 3'd0, 5'd0, 3'd0, F_ILL);

    // R6 moves
    send("R6", r53(7'b1110001, 5'd0, 5'd1, 3'd0, 5'd2), C64, 3'd0, 5'd29, 3'd0, F_ID);
    send("R6", r53(7'b1110001, 5'd0, 5'd1, 3'd0, 5'd2), C32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R6", r53(7'b1110001, 5'd0, 5'd1, 3'd0, 5'd2), ZX64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R6", r53(7'b1111001, 5'd0, 5'd3, 3'd0, 5'd4), C64, 3'd0, 5'd30, 3'd0, F_IS);
    send("R6", r53(7'b1111001, 5'd0, 5'd3, 3'd1, 5'd4), C64, 3'd0, 5'd0, 3'd0, F_ILL);

    // R7 rounding mode
    send("R7", r53(7'b0000001, 5'd2, 5'd1, 3'd5, 5'd3), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R7", r53(7'b0000001, 5'd2, 5'd1, 3'd6, 5'd3), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R7", r53(7'b0000001, 5'd2, 5'd1, 3'd7, 5'd3), C64, 3'd3, 5'd5, 3'd3, F_0);
    send("R7", r53(7'b0000001, 5'd2, 5'd1, 3'd7, 5'd3), C64, 3'd5, 5'd0, 3'd0, F_ILL);
    send("R7", r53(7'b0000001, 5'd2, 5'd1, 3'd7, 5'd3), C64, 3'd7, 5'd0, 3'd0, F_ILL);
    send("R7", fz(7'h43, 2'b01, 5'd3, 5'd2, 5'd1, 3'd7, 5'd4), C64, 3'd4, 5'd1, 3'd4, F_0);
    send("R7", r53(7'b0010001, 5'd2, 5'd1, 3'd1, 5'd3), C64, 3'd6, 5'd21, 3'd0, F_0);
    send("R7", r53(7'b1100001, 5'd0, 5'd1, 3'd7, 5'd2), C64, 3'd0, 5'd10, 3'd0, F_ID);

    // R8 even-pair rule
    send("R8", r53(7'b0000001, 5'd6, 5'd4, 3'd0, 5'd2), ZX32, 3'd0, 5'd5, 3'd0, F_0);
    send("R8", r53(7'b0000001, 5'd5, 5'd4, 3'd0, 5'd2), ZX32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R8", r53(7'b0000001, 5'd6, 5'd4, 3'd0, 5'd3), ZX32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R8", r53(7'b1100001, 5'd0, 5'd2, 3'd0, 5'd3), ZX32, 3'd0, 5'd10, 3'd0, F_ID);
    send("R8", r53(7'b1100001, 5'd0, 5'd3, 3'd0, 5'd2), ZX32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R8", r53(7'b1101001, 5'd0, 5'd5, 3'd0, 5'd2), ZX32, 3'd0, 5'd14, 3'd0, F_IS);
    send("R8", r53(7'b1101001, 5'd0, 5'd4, 3'd0, 5'd3), ZX32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R8", r53(7'b1010001, 5'd4, 5'd2, 3'd2, 5'd1), ZX32, 3'd0, 5'd25, 3'd0, F_ID);
    send("R8", fz(7'h43, 2'b01, 5'd7, 5'd2, 5'd4, 3'd0, 5'd6), ZX32, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R8", r53(7'b0000001, 5'd5, 5'd3, 3'd0, 5'd1), ZX64, 3'd0, 5'd5, 3'd0, F_0);
    send("R8", r53(7'b0000001, 5'd5, 5'd3, 3'd0, 5'd1), C32, 3'd0, 5'd5, 3'd0, F_0);

    // R9 no floating-point support
    send("R9", r53(7'b0000001, 5'd2, 5'd1, 3'd0, 5'd3), NOFP, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R9", fz(7'h4F, 2'b01, 5'd3, 5'd2, 5'd1, 3'd0, 5'd4), NOFP, 3'd0, 5'd0, 3'd0, F_ILL);

    // R11 unknown encodings
    send("R11", 32'h00A30313, C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R11", r53(7'b1111111, 5'd2, 5'd1, 3'd0, 5'd3), C64, 3'd0, 5'd0, 3'd0, F_ILL);
    send("R13", r53(7'b0000001, 5'd31, 5'd17, 3'd1, 5'd9), C64, 3'd0, 5'd5, 3'd1, F_0);

    // drain, then R12 stall behaviour
    while (q.size() != 0) @(negedge clk);
    bp = 1'b0; stall = 1'b1;
    repeat (2) @(posedge clk);
    send("R12", r53(7'b0001001, 5'd2, 5'd1, 3'd1, 5'd3), C64, 3'd0, 5'd7, 3'd1, F_0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12", in_ready === 1'b0, "in_ready while stalled", {31'd0, in_ready}, 32'd0);
      chk("R12", out_valid === 1'b1 && out_op === 5'd7, "held result op",
          {27'd0, out_op}, 32'd7);
    end
    stall = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R12", out_valid === 1'b0, "drained", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule